// File: doc/BRIEF.md
# Lane-Partitioned Saturating Adder/Subtractor

This is a purely combinational 64-bit adder/subtractor for packed small-integer data. A two-bit lane-size control decides at run time where the carry chain is cut, so the datapath acts as eight 8-bit, four 16-bit, two 32-bit or one 64-bit independent adder. Each lane can wrap modulo its width or clamp to its extreme value. Signed or unsigned interpretation is chosen for the whole word.

Subtraction inverts the second operand and injects a carry of one at the bottom of every lane. Each lane reports whether its true result fell outside its range. The overflow vector has one bit per byte, so software or a following stage can mask results byte by byte whatever the lane size.

Top module: `psat_adder`

## Requirements
- R1: `lane_mode_i` encodes the lane size as 0 = eight 8-bit lanes, 1 = four 16-bit lanes, 2 = two 32-bit lanes, 3 = one 64-bit lane. Lane k spans bytes k*L to k*L+L-1, where byte j is bits 8j+7:8j. No carry passes from one lane into the next.
- R2: With `sat_i` = 0, every lane of `res_o` holds the sum or difference modulo 2^w, where w is the lane width.
- R3: With `sub_i` = 1, each lane computes a minus b. It does this as a plus the bitwise inverse of b, plus a carry-in of 1 at that lane's lowest bit.
- R4: Signed addition (`sgn_i` = 1) flags overflow only when both operands have the same sign and the result sign differs. Operands of opposite sign never overflow.
- R5: Signed subtraction flags overflow only when the operand signs differ and the result sign differs from the sign of a.
- R6: Unsigned addition flags overflow on a carry out of the lane. Unsigned subtraction flags overflow when b is greater than a, which is a borrow.
- R7: A saturating signed lane returns 2^(w-1)-1 on positive overflow and -2^(w-1) on negative overflow.
- R8: A saturating unsigned lane returns all ones on addition overflow and zero on subtraction overflow.
- R9: `ovf_o[j]` is the overflow flag of the lane that contains byte j. All bytes of one lane carry the same flag.
- R10: The overflow flags are produced in wrapping mode too. `sat_i` changes only `res_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | First operand (minuend), packed lanes |
| b_i | input | 64 | Second operand (subtrahend), packed lanes |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| lane_mode_i | input | 2 | Lane size select (see R1) |
| sat_i | input | 1 | 1 = clamp overflowing lanes, 0 = wrap |
| sgn_i | input | 1 | 1 = signed lanes, 0 = unsigned lanes |
| res_o | output | 64 | Packed per-lane result |
| ovf_o | output | 8 | Per-byte copy of its lane's overflow flag |

## Verification
The hardest situations to reach are the ones where the cut point alone decides the answer. One case is a carry that must ripple across a byte border inside a 16-, 32- or 64-bit lane but stop at the lane edge. The other is negative overflow in a wide lane, whose clamp value differs between the top byte and the lower bytes.

Hand-built vectors place all-ones bytes under a +1 so that the carry runs to the lane edge, and put extreme values only in the top lane. Each is then applied under several lane sizes. A sweep of pseudo-random operands, mixed with extreme byte patterns, covers every combination of lane size, add/subtract, signedness and saturation, and compares each result against a lane model that uses wide integers.

// File: rtl/psat_pkg.sv
package psat_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    LM_B8  = 2'd0,
    LM_H16 = 2'd1,
    LM_W32 = 2'd2,
    LM_D64 = 2'd3
  } lane_mode_e;

  typedef struct packed {
    logic              c_out;
    logic              c_msb;
    logic [BYTE_W-1:0] sum;
  } slice_t;

  // one byte of the ripple chain, exposing carry into and out of the msb
  function automatic slice_t byte_add(input logic [BYTE_W-1:0] x,
                                      input logic [BYTE_W-1:0] y,
                                      input logic              cin);
    slice_t            s;
    logic [BYTE_W-1:0] low;
    logic [1:0]        top;
    low   = {1'b0, x[BYTE_W-2:0]} + {1'b0, y[BYTE_W-2:0]} + {{(BYTE_W-1){1'b0}}, cin};
    top   = {1'b0, x[BYTE_W-1]} + {1'b0, y[BYTE_W-1]} + {1'b0, low[BYTE_W-1]};
    s.c_msb = low[BYTE_W-1];
    s.c_out = top[1];
    s.sum   = {top[0], low[BYTE_W-2:0]};
    return s;
  endfunction

  // overflow of a lane, judged at its top byte
  function automatic logic lane_overflow(input logic sgn, input logic sub,
                                         input logic c_msb, input logic c_out);
    if (sgn) return c_msb ^ c_out;
    return sub ? ~c_out : c_out;
  endfunction

  // clamp value of one byte of an overflowing lane
  function automatic logic [BYTE_W-1:0] clamp_byte(input logic sgn, input logic sub,
                                                   input logic neg, input logic is_top);
    logic [BYTE_W-1:0] v;
    if (!sgn)      v = sub ? '0 : '1;
    else if (neg)  v = is_top ? {1'b1, {(BYTE_W-1){1'b0}}} : '0;
    else           v = is_top ? {1'b0, {(BYTE_W-1){1'b1}}} : '1;
    return v;
  endfunction

endpackage

// File: rtl/psat_lane_map.sv
module psat_lane_map
  import psat_pkg::*;
#(
  parameter  int NBYTES = 8,
  localparam int IDX_W  = $clog2(NBYTES)
) (
  input  logic [1:0]        lane_mode_i,
  output logic [IDX_W-1:0]  span_mask_o,
  output logic [NBYTES-1:0] seg_first_o,
  output logic [NBYTES-1:0] seg_last_o
);

  lane_mode_e mode;
  assign mode = lane_mode_e'(lane_mode_i);

  always_comb begin
    unique case (mode)
      LM_B8:   span_mask_o = IDX_W'(0);
      LM_H16:  span_mask_o = IDX_W'(1);
      LM_W32:  span_mask_o = IDX_W'(3);
      default: span_mask_o = IDX_W'(7);
    endcase
  end

  for (genvar gi = 0; gi < NBYTES; gi++) begin : g_byte
    localparam logic [IDX_W-1:0] IDX = IDX_W'(gi);
    assign seg_first_o[gi] = ((IDX & span_mask_o) == '0);
    assign seg_last_o[gi]  = ((IDX & span_mask_o) == span_mask_o);
  end

endmodule

// File: rtl/psat_carry_chain.sv
module psat_carry_chain
  import psat_pkg::*;
#(
  parameter  int NBYTES = 8,
  localparam int DATA_W = NBYTES * BYTE_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic [NBYTES-1:0] seg_first_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [NBYTES-1:0] c_msb_o,
  output logic [NBYTES-1:0] c_out_o
);

  logic [DATA_W-1:0] b_eff;
  assign b_eff = sub_i ? ~b_i : b_i;

  always_comb begin
    logic   carry;
    logic   cin;
    slice_t s;
    carry = 1'b0;
    for (int i = 0; i < NBYTES; i++) begin
      cin = seg_first_i[i] ? sub_i : carry;
      s   = byte_add(a_i[i*BYTE_W +: BYTE_W], b_eff[i*BYTE_W +: BYTE_W], cin);
      sum_o[i*BYTE_W +: BYTE_W] = s.sum;
      c_msb_o[i] = s.c_msb;
      c_out_o[i] = s.c_out;
      carry      = s.c_out;
    end
  end

endmodule

// File: rtl/psat_clamp.sv
module psat_clamp
  import psat_pkg::*;
#(
  parameter  int NBYTES = 8,
  localparam int DATA_W = NBYTES * BYTE_W,
  localparam int IDX_W  = $clog2(NBYTES)
) (
  input  logic [DATA_W-1:0] sum_i,
  input  logic [NBYTES-1:0] c_msb_i,
  input  logic [NBYTES-1:0] c_out_i,
  input  logic [NBYTES-1:0] seg_last_i,
  input  logic [IDX_W-1:0]  span_mask_i,
  input  logic              sgn_i,
  input  logic              sub_i,
  input  logic              sat_i,
  output logic [DATA_W-1:0] res_o,
  output logic [NBYTES-1:0] ovf_o
);

  // per-byte candidates; only entries at a lane's top byte are consumed
  logic [NBYTES-1:0] lane_ovf;
  logic [NBYTES-1:0] lane_neg;

  for (genvar gi = 0; gi < NBYTES; gi++) begin : g_top
    assign lane_ovf[gi] = lane_overflow(sgn_i, sub_i, c_msb_i[gi], c_out_i[gi]);
    assign lane_neg[gi] = ~sum_i[gi*BYTE_W + BYTE_W-1];
  end

  for (genvar gi = 0; gi < NBYTES; gi++) begin : g_out
    logic [IDX_W-1:0] owner;
    assign owner = IDX_W'(gi) | span_mask_i;
    assign ovf_o[gi] = lane_ovf[owner];
    assign res_o[gi*BYTE_W +: BYTE_W] =
      (sat_i && lane_ovf[owner]) ? clamp_byte(sgn_i, sub_i, lane_neg[owner], seg_last_i[gi])
                                 : sum_i[gi*BYTE_W +: BYTE_W];

    if (gi < NBYTES-1) begin : g_rep
      always_comb begin
        if (!seg_last_i[gi]) begin
          // R9
          lane_flag_rep_chk: assert (ovf_o[gi] == ovf_o[gi+1]);
        end
      end
    end

    always_comb begin
      if (sat_i && sgn_i && ovf_o[gi] && seg_last_i[gi]) begin
        // R7
        signed_clamp_top_chk: assert (res_o[gi*BYTE_W +: BYTE_W] == {1'b0, {(BYTE_W-1){1'b1}}}
                                   || res_o[gi*BYTE_W +: BYTE_W] == {1'b1, {(BYTE_W-1){1'b0}}});
      end
    end
  end

endmodule

// File: rtl/psat_adder.sv
module psat_adder
  import psat_pkg::*;
#(
  parameter  int NBYTES = 8,
  localparam int DATA_W = NBYTES * BYTE_W,
  localparam int IDX_W  = $clog2(NBYTES)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic [1:0]        lane_mode_i,
  input  logic              sat_i,
  input  logic              sgn_i,
  output logic [DATA_W-1:0] res_o,
  output logic [NBYTES-1:0] ovf_o
);

  // internal events brought out for the checks below
  logic [IDX_W-1:0]  span_mask;
  logic [NBYTES-1:0] seg_first;
  logic [NBYTES-1:0] seg_last;
  logic [DATA_W-1:0] raw_sum;
  logic [NBYTES-1:0] c_msb;
  logic [NBYTES-1:0] c_out;

  psat_lane_map #(.NBYTES(NBYTES)) map_i (
    .lane_mode_i (lane_mode_i),
    .span_mask_o (span_mask),
    .seg_first_o (seg_first),
    .seg_last_o  (seg_last)
  );

  psat_carry_chain #(.NBYTES(NBYTES)) chain_i (
    .a_i         (a_i),
    .b_i         (b_i),
    .sub_i       (sub_i),
    .seg_first_i (seg_first),
    .sum_o       (raw_sum),
    .c_msb_o     (c_msb),
    .c_out_o     (c_out)
  );

  psat_clamp #(.NBYTES(NBYTES)) clamp_i (
    .sum_i       (raw_sum),
    .c_msb_i     (c_msb),
    .c_out_i     (c_out),
    .seg_last_i  (seg_last),
    .span_mask_i (span_mask),
    .sgn_i       (sgn_i),
    .sub_i       (sub_i),
    .sat_i       (sat_i),
    .res_o       (res_o),
    .ovf_o       (ovf_o)
  );

  always_comb begin
    if (!sat_i) begin
      // R2
      wrap_pass_chk: assert (res_o == raw_sum);
    end
    for (int i = 0; i < NBYTES; i++) begin
      if (seg_last[i] && sgn_i && !sub_i && (a_i[i*BYTE_W+BYTE_W-1] != b_i[i*BYTE_W+BYTE_W-1])) begin
        // R4
        opp_sign_add_chk: assert (!ovf_o[i]);
      end
      if (seg_last[i] && sgn_i && sub_i && (a_i[i*BYTE_W+BYTE_W-1] == b_i[i*BYTE_W+BYTE_W-1])) begin
        // R5
        same_sign_sub_chk: assert (!ovf_o[i]);
      end
      if (sat_i && !sgn_i && ovf_o[i]) begin
        // R8
        unsigned_clamp_chk: assert (res_o[i*BYTE_W +: BYTE_W] == (sub_i ? {BYTE_W{1'b0}} : {BYTE_W{1'b1}}));
      end
    end
  end

endmodule

// File: tb/psat_adder_tb.sv
module psat_adder_tb_top;

  localparam int NBYTES = 8;
  localparam int DW     = NBYTES * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] a, b, res;
  logic          sub, sat, sgn;
  logic [1:0]    mode;
  logic [7:0]    ovf;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  psat_adder #(.NBYTES(NBYTES)) dut_i (
    .a_i(a), .b_i(b), .sub_i(sub), .lane_mode_i(mode),
    .sat_i(sat), .sgn_i(sgn), .res_o(res), .ovf_o(ovf)
  );

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic        sub;
    logic [1:0]  mode;
    logic        sat;
    logic        sgn;
    logic [63:0] res;
    logic [7:0]  ovf;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{64'h7F7F7F7F7F7F7F7F, 64'h0101010101010101, 1'b0, 2'd0, 1'b1, 1'b1, 64'h7F7F7F7F7F7F7F7F, 8'hFF},
    '{64'h7F7F7F7F7F7F7F7F, 64'h0101010101010101, 1'b0, 2'd0, 1'b0, 1'b1, 64'h8080808080808080, 8'hFF},
    '{64'hFFFFFFFFFFFFFFFF, 64'h0101010101010101, 1'b0, 2'd0, 1'b1, 1'b0, 64'hFFFFFFFFFFFFFFFF, 8'hFF},
    '{64'hFFFFFFFFFFFFFFFF, 64'h0101010101010101, 1'b0, 2'd0, 1'b0, 1'b0, 64'h0000000000000000, 8'hFF},
    '{64'h00FF00FF00FF00FF, 64'h0001000100010001, 1'b0, 2'd1, 1'b0, 1'b0, 64'h0100010001000100, 8'h00},
    '{64'h0000000000000000, 64'h0000000000000001, 1'b1, 2'd3, 1'b1, 1'b0, 64'h0000000000000000, 8'hFF},
    '{64'h0000000000000000, 64'h0000000000000001, 1'b1, 2'd3, 1'b0, 1'b0, 64'hFFFFFFFFFFFFFFFF, 8'hFF},
    '{64'h8000000080000000, 64'h0000000100000001, 1'b1, 2'd2, 1'b1, 1'b1, 64'h8000000080000000, 8'hFF},
    '{64'h8080808080808080, 64'h7F7F7F7F7F7F7F7F, 1'b0, 2'd0, 1'b1, 1'b1, 64'hFFFFFFFFFFFFFFFF, 8'h00},
    '{64'h00FF00FF00FF00FF, 64'h0001000100010001, 1'b0, 2'd0, 1'b0, 1'b0, 64'h0000000000000000, 8'h55},
    '{64'h8080808080808080, 64'h8080808080808080, 1'b1, 2'd0, 1'b1, 1'b1, 64'h0000000000000000, 8'h00},
    '{64'h7FFFFFFF00000000, 64'h0000000100000000, 1'b0, 2'd2, 1'b1, 1'b1, 64'h7FFFFFFF00000000, 8'hF0},
    '{64'h8000000000000000, 64'h0000000000000001, 1'b1, 2'd3, 1'b1, 1'b1, 64'h8000000000000000, 8'hFF}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R7 R4";    1: return "R2 R10";  2: return "R8 R6";
      3: return "R2 R6";    4: return "R1";      5: return "R8 R3";
      6: return "R3 R6";    7: return "R5 R7";   8: return "R4";
      9: return "R1 R9";    10: return "R5";     11: return "R9 R7";
      default: return "R7 R5";
    endcase
  endfunction

  // lane model on wide integers, written from the requirements
  function automatic logic [71:0] model(input logic [63:0] x_a, input logic [63:0] x_b,
                                        input logic x_sub, input logic [1:0] x_mode,
                                        input logic x_sat, input logic x_sgn);
    int          w = 8 << x_mode;
    int          n = 64 / w;
    logic [63:0] r_all = '0;
    logic [7:0]  f_all = '0;
    logic [63:0] mask = (64'(1) << w) - 64'(1);
    for (int l = 0; l < n; l++) begin
      logic [65:0] x, y, r, mx, mn, val;
      logic        of;
      x = {2'b0, (x_a >> (l*w)) & mask};
      y = {2'b0, (x_b >> (l*w)) & mask};
      if (x_sgn) begin
        if (x[w-1]) x = x | ~{2'b0, mask};
        if (y[w-1]) y = y | ~{2'b0, mask};
      end
      r  = x_sub ? x - y : x + y;
      mx = {2'b0, mask >> 1};
      mn = ~mx;
      val = r;
      if (x_sgn) begin
        of = ($signed(r) > $signed(mx)) || ($signed(r) < $signed(mn));
        if (of && x_sat) val = ($signed(r) > $signed(mx)) ? mx : mn;
      end else begin
        of = x_sub ? (x < y) : r[w];
        if (of && x_sat) val = x_sub ? 66'd0 : {2'b0, mask};
      end
      r_all = r_all | ((val[63:0] & mask) << (l*w));
      if (of) for (int j = l*(w/8); j < (l+1)*(w/8); j++) f_all[j] = 1'b1;
    end
    return {r_all, f_all};
  endfunction

  task automatic drive(input logic [63:0] va, input logic [63:0] vb, input logic vs,
                       input logic [1:0] vm, input logic vt, input logic vg);
    @(negedge clk);
    a = va; b = vb; sub = vs; mode = vm; sat = vt; sgn = vg;
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input logic [63:0] er, input logic [7:0] eo);
    n_cmp++;
    if (res !== er || ovf !== eo) begin
      n_bad++;
      $display("FAIL %s: res=%h ovf=%h expected res=%h ovf=%h (a=%h b=%h sub=%0b mode=%0d sat=%0b sgn=%0b)",
               tag, res, ovf, er, eo, a, b, sub, mode, sat, sgn);
    end
  endtask

  initial begin
    a = '0; b = '0; sub = 1'b0; mode = 2'd0; sat = 1'b0; sgn = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R2 reset state", 64'h0, 8'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].a, VEC[i].b, VEC[i].sub, VEC[i].mode, VEC[i].sat, VEC[i].sgn);
      check(vec_tag(i), VEC[i].res, VEC[i].ovf);
    end

    // R1: carry of a full 64-bit ones run must stop at every lane edge
    for (int m = 0; m < 4; m++) begin
      logic [71:0] e;
      drive(64'hFFFFFFFFFFFFFFFF, 64'h1, 1'b0, 2'(m), 1'b0, 1'b0);
      e = model(64'hFFFFFFFFFFFFFFFF, 64'h1, 1'b0, 2'(m), 1'b0, 1'b0);
      check("R1 R6 ripple to lane edge", e[71:8], e[7:0]);
    end

    // R10: sat off vs on gives identical flags
    for (int m = 0; m < 4; m++) begin
      logic [7:0] f0;
      drive(64'h7F00FFFF80000001, 64'h7FFF0001FFFFFFFF, 1'b0, 2'(m), 1'b0, 1'b1);
      f0 = ovf;
      drive(64'h7F00FFFF80000001, 64'h7FFF0001FFFFFFFF, 1'b0, 2'(m), 1'b1, 1'b1);
      check("R10 flags independent of sat", res, f0);
    end

    // sweep of all control combinations against the model
    for (int k = 0; k < 40; k++) begin
      logic [63:0] pa, pb;
      pa = {$urandom, $urandom};
      pb = {$urandom, $urandom};
      if (k % 5 == 1) pa = 64'h7F807FFF80000000 ^ {56'h0, 8'(k)};
      if (k % 5 == 2) pb = 64'h80FF00017FFFFFFF;
      if (k % 5 == 3) pb = pa;
      for (int c = 0; c < 32; c++) begin
        logic [71:0] e;
        drive(pa, pb, c[0], c[2:1], c[3], c[4]);
        e = model(pa, pb, c[0], c[2:1], c[3], c[4]);
        check("R1 R2 R3 R4 R5 R6 R7 R8 R9 sweep", e[71:8], e[7:0]);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int t = 0; t < 150000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule